// File: doc/BRIEF.md
# Addressable Serial Receiver

This block is an asynchronous serial receiver. It watches a single idle-high line and rebuilds words from frames that hold one start bit, eight or nine data bits sent least significant bit first, and one stop bit. Timing comes from a one-clock enable pulse at sixteen times the bit rate. The enable is produced outside the block. A word that is received without error appears on a parallel byte output, with the optional ninth bit on its own output. A one-clock valid strobe marks each accepted word.

In a network with several nodes, the receiver can filter words. When filtering is on, only words whose marker bit is set are kept. These are taken as node addresses. The marker bit is bit 7 for 8-bit words and bit 8 for 9-bit words. All other words are dropped without any sign. An interrupt request pulse can go with each accepted word. The receiver runs only while both the global enable and its own enable are high. Dropping either one stops the frame in progress and clears the receiver.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rxData`, `rxBit8`, `dataValid` and `irqReq` are all 0.
- R2: With `nineBit`=0, a frame is decoded as follows. The low start bit is followed by 8 data bits sent LSB first, each 16 ticks long, and then a high stop bit. `rxData` takes the byte, `rxBit8` reads 0, and `dataValid` is high for exactly one clock.
- R3: With `nineBit`=1, a frame carries 9 data bits. The first 8 go to `rxData[7:0]` and the ninth goes to `rxBit8`.
- R4: With `addrDetectEn`=1 and `nineBit`=0, a word is accepted only if data bit 7 is 1. Any other word gives no `dataValid`, and the outputs keep their previous values.
- R5: With `addrDetectEn`=1 and `nineBit`=1, a word is accepted only if the ninth bit is 1. Bit 7 has no effect on this choice.
- R6: With `addrDetectEn`=0, every frame that has a high stop bit is accepted.
- R7: `irqReq` pulses in the same clock as `dataValid`, but only when `rxIrqEn` is 1. It never pulses without `dataValid`.
- R8: While `globalEn` or `rxEnable` is 0, no word is received. On the following clock, `rxData`, `rxBit8` and `dataValid` read 0.
- R9: If `rxEnable` is cleared partway through a frame, the frame is aborted and the outputs are cleared. The next complete frame after re-enabling is received correctly.
- R10: A start bit is confirmed only if the line is still low at mid-bit (tick 8). A shorter low pulse returns the receiver to idle and produces no word.
- R11: A frame whose stop bit is sampled low is dropped, and no `dataValid` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-clock enable at 16x the bit rate |
| rxIn | input | 1 | Serial receive line, idle high |
| globalEn | input | 1 | Global serial port enable |
| rxEnable | input | 1 | Receiver enable; clearing it aborts and clears |
| nineBit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| addrDetectEn | input | 1 | Keep only words whose marker bit is set |
| rxIrqEn | input | 1 | Allow an interrupt pulse for each accepted word |
| rxData | output | 8 | Low 8 bits of the last accepted word |
| rxBit8 | output | 1 | Ninth bit of the last accepted word (0 in 8-bit format) |
| dataValid | output | 1 | One-clock strobe for each accepted word |
| irqReq | output | 1 | One-clock interrupt request for each accepted word |

## Verification
Random frames vary the data value, the word width, the filter enable and the interrupt enable together. This separates three cases: a word kept because of bit 7, a word kept because of the ninth bit, and a word kept only because filtering is off. Directed frames cover the other cases. One sets bit 7 but clears the ninth bit in 9-bit mode, which shows that the marker position follows the format. A short start glitch and a low stop bit each check that a broken frame is rejected. Frames sent while an enable is low, and a frame aborted partway through, show that the receiver resets and then recovers.

// File: rtl/uart_addr_rx_pkg.sv
package uart_addr_rx_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  typedef struct packed {
    logic             clear;
    logic             sample;
    logic [IDX_W-1:0] bitIdx;
    logic             commit;
  } rxStrobe_t;
endpackage

// File: rtl/uart_addr_rx_ctrl.sv
module uart_addr_rx_ctrl
  import uart_addr_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      rxS,
  input  logic      nineBit,
  output rxStrobe_t strb
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             atEnd;

  assign lastIdx = nineBit ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign atEnd   = tick && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (!run) begin
      state <= ST_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (!rxS) state <= ST_START;
        end
        ST_START: begin
          if (tick) begin
            if (cnt == MID_CNT) begin
              cnt   <= '0;
              state <= rxS ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (cnt == LAST_CNT) begin
              cnt <= '0;
              if (idx == lastIdx) state <= ST_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (cnt == LAST_CNT) begin
              cnt   <= '0;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clear  = !run;
    strb.sample = (state == ST_DATA) && atEnd;
    strb.bitIdx = idx;
    strb.commit = (state == ST_STOP) && atEnd && rxS;
  end
endmodule

// File: rtl/uart_addr_rx_dp.sv
module uart_addr_rx_dp
  import uart_addr_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxStrobe_t         strb,
  input  logic              rxS,
  input  logic              nineBit,
  input  logic              addrDetectEn,
  input  logic              rxIrqEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              dataValid,
  output logic              irqReq
);
  logic [DATA_W:0] shReg;
  logic            topBit;
  logic            markBit;
  logic            accept;

  assign topBit  = nineBit & shReg[DATA_W];
  assign markBit = nineBit ? shReg[DATA_W] : shReg[DATA_W-1];
  assign accept  = strb.commit && (!addrDetectEn || markBit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg     <= '0;
      rxData    <= '0;
      rxBit8    <= 1'b0;
      dataValid <= 1'b0;
      irqReq    <= 1'b0;
    end else if (strb.clear) begin
      shReg     <= '0;
      rxData    <= '0;
      rxBit8    <= 1'b0;
      dataValid <= 1'b0;
      irqReq    <= 1'b0;
    end else begin
      if (strb.sample) begin
        for (int i = 0; i <= DATA_W; i++) begin
          if (strb.bitIdx == IDX_W'(i)) shReg[i] <= rxS;
        end
      end
      dataValid <= accept;
      irqReq    <= accept && rxIrqEn;
      if (accept) begin
        rxData <= shReg[DATA_W-1:0];
        rxBit8 <= topBit;
      end
    end
  end
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uart_addr_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxIn,
  input  logic              globalEn,
  input  logic              rxEnable,
  input  logic              nineBit,
  input  logic              addrDetectEn,
  input  logic              rxIrqEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit8,
  output logic              dataValid,
  output logic              irqReq
);
  logic [1:0] syncReg;
  logic       rxS;
  logic       run;
  rxStrobe_t  strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncReg <= 2'b11;
    else        syncReg <= {syncReg[0], rxIn};
  end

  assign rxS = syncReg[1];
  assign run = globalEn && rxEnable;

  uart_addr_rx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick16),
    .rxS(rxS), .nineBit(nineBit), .strb(strb)
  );

  uart_addr_rx_dp #(.DATA_W(DATA_W)) dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rxS(rxS),
    .nineBit(nineBit), .addrDetectEn(addrDetectEn), .rxIrqEn(rxIrqEn),
    .rxData(rxData), .rxBit8(rxBit8), .dataValid(dataValid), .irqReq(irqReq)
  );
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              globalEn,
  input logic              rxEnable,
  input logic              nineBit,
  input logic              addrDetectEn,
  input logic              rxIrqEn,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit8,
  input logic              dataValid,
  input logic              irqReq
);
  a_r2_valid_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |=> !dataValid);

  a_r2_bit8_zero_in_8bit: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && !$past(nineBit)) |-> !rxBit8);

  a_r4_marker_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && $past(addrDetectEn) && !$past(nineBit)) |-> rxData[DATA_W-1]);

  a_r5_marker_bit8: assert property (@(posedge clk) disable iff (!rst_n)
    (dataValid && $past(addrDetectEn) && $past(nineBit)) |-> rxBit8);

  a_r7_irq_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (dataValid && $past(rxIrqEn)));

  a_r8_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !(globalEn && rxEnable) |=> (!dataValid && !irqReq && rxData == '0 && !rxBit8));
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .globalEn(globalEn), .rxEnable(rxEnable),
  .nineBit(nineBit), .addrDetectEn(addrDetectEn), .rxIrqEn(rxIrqEn),
  .rxData(rxData), .rxBit8(rxBit8), .dataValid(dataValid), .irqReq(irqReq)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  localparam int BIT_CLKS = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxIn = 1'b1;
  logic       globalEn = 1'b1;
  logic       rxEnable = 1'b1;
  logic       nineBit = 1'b0;
  logic       addrDetectEn = 1'b0;
  logic       rxIrqEn = 1'b0;
  logic [7:0] rxData;
  logic       rxBit8;
  logic       dataValid;
  logic       irqReq;

  int errors = 0;
  int checks = 0;
  int validCnt = 0;
  int irqCnt = 0;
  int orphanIrq = 0;
  logic [7:0] lastData = '0;
  logic       lastB8 = 1'b0;
  bit         done = 0;
  int         tickDiv = 0;

  always #10 clk = ~clk;

  uart_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxIn(rxIn),
    .globalEn(globalEn), .rxEnable(rxEnable), .nineBit(nineBit),
    .addrDetectEn(addrDetectEn), .rxIrqEn(rxIrqEn),
    .rxData(rxData), .rxBit8(rxBit8), .dataValid(dataValid), .irqReq(irqReq)
  );

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    tick16 <= (tickDiv == 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dataValid) begin
        validCnt++;
        lastData = rxData;
        lastB8   = rxBit8;
      end
      if (irqReq) begin
        irqCnt++;
        if (!dataValid) orphanIrq++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expAccept(input logic [8:0] d, input bit nine, input bit addrEn);
    if (!addrEn) return 1'b1;
    return nine ? d[8] : d[7];
  endfunction

  task automatic sendFrame(input logic [8:0] d, input bit nine, input bit stopVal);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxIn = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxIn = stopVal;
    if (stopVal) begin
      repeat (BIT_CLKS) @(negedge clk);
    end else begin
      repeat (48) @(negedge clk);
      rxIn = 1'b1;
      repeat (16) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic frameCheck(input logic [8:0] d, input bit nine, input bit addrEn, input bit irqEn);
    int v0;
    int q0;
    bit acc;
    string tag;
    nineBit = nine;
    addrDetectEn = addrEn;
    rxIrqEn = irqEn;
    v0 = validCnt;
    q0 = irqCnt;
    sendFrame(d, nine, 1'b1);
    acc = expAccept(d, nine, addrEn);
    tag = !addrEn ? "R6" : (nine ? "R5" : "R4");
    check((validCnt - v0) == int'(acc), {tag, " accept count"}, 32'(validCnt - v0), 32'(acc));
    if (acc) begin
      check(lastData == d[7:0], nine ? "R3 low byte" : "R2 byte", 32'(lastData), 32'(d[7:0]));
      check(lastB8 == (nine & d[8]), nine ? "R3 ninth bit" : "R2 ninth bit zero",
            32'(lastB8), 32'(nine & d[8]));
    end
    check((irqCnt - q0) == int'(acc & irqEn), "R7 irq count", 32'(irqCnt - q0), 32'(acc & irqEn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v0;
    logic [8:0] d;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rxData == 8'h00, "R1 data", 32'(rxData), 0);
    check(rxBit8 == 1'b0, "R1 bit8", 32'(rxBit8), 0);
    check(dataValid == 1'b0 && irqReq == 1'b0, "R1 strobes", 32'({dataValid, irqReq}), 0);
    repeat (20) @(negedge clk);

    // Directed: plain 8-bit and 9-bit words
    frameCheck(9'h0A5, 1'b0, 1'b0, 1'b1);
    frameCheck(9'h13C, 1'b1, 1'b0, 1'b0);
    // R4 filter: bit7 low dropped, high kept
    frameCheck(9'h07F, 1'b0, 1'b1, 1'b1);
    frameCheck(9'h081, 1'b0, 1'b1, 1'b1);
    // R5: bit7 set but ninth clear is dropped, ninth set kept
    frameCheck(9'h0FF, 1'b1, 1'b1, 1'b1);
    frameCheck(9'h101, 1'b1, 1'b1, 1'b1);

    // R10: short start glitch
    v0 = validCnt;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (16) @(negedge clk);
    rxIn = 1'b1;
    repeat (200) @(negedge clk);
    check(validCnt == v0, "R10 glitch ignored", 32'(validCnt - v0), 0);
    frameCheck(9'h05A, 1'b0, 1'b0, 1'b0);

    // R11: low stop bit
    v0 = validCnt;
    nineBit = 1'b0; addrDetectEn = 1'b0;
    sendFrame(9'h0C3, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    check(validCnt == v0, "R11 bad stop dropped", 32'(validCnt - v0), 0);

    // R8: global enable low
    globalEn = 1'b0;
    v0 = validCnt;
    sendFrame(9'h0E7, 1'b0, 1'b1);
    check(validCnt == v0, "R8 global off no word", 32'(validCnt - v0), 0);
    check(rxData == 8'h00, "R8 data cleared", 32'(rxData), 0);
    globalEn = 1'b1;
    rxEnable = 1'b0;
    sendFrame(9'h0E7, 1'b0, 1'b1);
    check(validCnt == v0, "R8 rx off no word", 32'(validCnt - v0), 0);
    rxEnable = 1'b1;
    repeat (20) @(negedge clk);

    // R9: abort mid-frame
    frameCheck(9'h1E5, 1'b1, 1'b0, 1'b0);
    v0 = validCnt;
    rxIn = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      rxIn = i[0];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
    check(rxData == 8'h00 && rxBit8 == 1'b0, "R9 abort clears", 32'({rxBit8, rxData}), 0);
    rxIn = 1'b1;
    repeat (100) @(negedge clk);
    rxEnable = 1'b1;
    repeat (100) @(negedge clk);
    check(validCnt == v0, "R9 no word from aborted frame", 32'(validCnt - v0), 0);
    frameCheck(9'h03C, 1'b0, 1'b0, 1'b1);

    // Random mix
    for (int n = 0; n < 40; n++) begin
      d = 9'($urandom);
      frameCheck(d, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    check(orphanIrq == 0, "R7 irq without valid", 32'(orphanIrq), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule